// File: doc/BRIEF.md
# Buffered 16-bit Timer with Compare-Triggered Reset

This block is a 16-bit up-counting timer behind a byte-wide register port. An enabled prescaler divides the count rate by 1, 2, 4 or 8. When the timer passes its all-ones value it wraps to zero and sets a sticky overflow flag. That flag, together with an enable bit, drives an interrupt line.

A wide-access mode lets software move all 16 bits as one coherent value. In this mode the upper byte goes through a holding register: reading the lower byte captures the live upper byte into it, and writing the lower byte commits it. A compare unit can also be armed. When the counter is about to advance and already equals the 16-bit compare value, it returns to zero instead, so the compare value sets the period. The same event sends a one-cycle start-conversion pulse to an external converter.

The register port is a plain strobe interface with no back-pressure. A write or a read completes in the cycle its strobe is high, and read data is combinational from the address. The block has no streaming data path.

Top module: `tmr_buf16`

## Requirements
- R1: After reset every register reads 0x00, and `irq` and `soc_pulse` are low.
- R2: While control bit 0 (run) is 1 and `count_en` is 1, the counter advances once every 1, 2, 4 or 8 enabled cycles, selected by control bits 3:2 = 0, 1, 2, 3. It steps from 0xFFFF back to 0x0000.
- R3: The overflow flag (address 5, bit 0) is set on a wrap. Writing address 5 with bit 0 = 0 clears it, and writing bit 0 = 1 changes nothing. `irq` is high exactly while the flag and control bit 5 are both 1.
- R4: With control bit 1 (wide) set, a read of address 0 returns the live low byte and copies the live high byte into the holding register. A read of address 1 returns the holding register.
- R5: With wide set, a write to address 1 loads only the holding register. A write to address 0 loads the counter with {holding register, data} in one cycle.
- R6: With wide clear, addresses 0 and 1 read and write the live low and high counter bytes directly.
- R7: A write to address 0 restarts the prescaler phase. A write to address 1 leaves the phase unchanged.
- R8: With control bit 4 (compare mode) set, a counter step taken while the count equals the compare value (address 2 low byte, address 3 high byte) loads 0 instead. `soc_pulse` is then high for the next cycle if `conv_en` was 1.
- R9: A write that loads the live counter (address 0, or address 1 with wide clear) in the same cycle as a compare match keeps the written value.
- R10: A compare reset never sets the overflow flag, even when the compare value is 0xFFFF.
- R11: With `count_en` low, or with run clear, the counter and the prescaler phase hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on address 0) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| count_en | input | 1 | External count-enable gate |
| conv_en | input | 1 | Converter enable, gates `soc_pulse` |
| soc_pulse | output | 1 | One-cycle start-conversion pulse |
| irq | output | 1 | Overflow interrupt |

## Verification
Counting is driven with bursts of exactly known length at several prescaler settings. The burst lengths separate a wrong divide ratio from a prescaler phase that is not restarted by a low-byte write but is wrongly restarted by a high-byte write. Wide-mode reads are taken while the timer runs across a high-byte carry, so a snapshot shows whether the upper byte comes from the live count or from the holding register. Compare runs use a small period, the all-ones period next to a wrap, and a counter write landing on the match cycle. These cases tell a reset from an overflow and show which of two same-cycle updates wins. A cycle-accurate behavioural model checks the interrupt, the pulse and the addressed read data on every clock.

// File: rtl/tmr_buf16_pkg.sv
package tmr_buf16_pkg;
  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP_LO = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMP_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT   = 3'd5;

  typedef struct packed {
    logic       irq_en;   // bit 5
    logic       cmp_mode; // bit 4
    logic [1:0] psel;     // bits 3:2
    logic       wide;     // bit 1
    logic       run;      // bit 0
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/tmr_buf16_prescale.sv
module tmr_buf16_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PC_W = (1 << SEL_W) - 1;

  logic [PC_W-1:0] phase;
  logic [PC_W-1:0] limit;

  assign limit = (PC_W'(1) << sel) - PC_W'(1);
  assign tick  = adv && (phase == limit);

  always_ff @(posedge clk) begin
    if (!rst_n)       phase <= '0;
    else if (clr)     phase <= '0;
    else if (adv)     phase <= (phase == limit) ? '0 : phase + PC_W'(1);
  end
endmodule

// File: rtl/tmr_buf16_count.sv
module tmr_buf16_count #(
  parameter int BYTE_W = 8,
  localparam int CW    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              match,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic              rd_lo,
  input  logic              wide,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CW-1:0]     cnt,
  output logic [BYTE_W-1:0] hbuf,
  output logic              cnt_load,
  output logic              wrap
);
  assign cnt_load = wr_lo || (wr_hi && !wide);
  assign wrap     = tick && !match && !cnt_load && (cnt == {CW{1'b1}});

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (wr_lo)            cnt <= {(wide ? hbuf : cnt[CW-1:BYTE_W]), wdata};
    else if (wr_hi && !wide)   cnt[CW-1:BYTE_W] <= wdata;
    else if (match)            cnt <= '0;
    else if (tick)             cnt <= cnt + CW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                hbuf <= '0;
    else if (wr_hi && wide)    hbuf <= wdata;
    else if (rd_lo && wide)    hbuf <= cnt[CW-1:BYTE_W];
  end
endmodule

// File: rtl/tmr_buf16_cmp.sv
module tmr_buf16_cmp #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp,
  input  logic          mode,
  input  logic          tick,
  input  logic          conv_en,
  output logic          match,
  output logic          soc_pulse
);
  assign match = mode && tick && (cnt == cmp);

  always_ff @(posedge clk) begin
    if (!rst_n) soc_pulse <= 1'b0;
    else        soc_pulse <= match && conv_en;
  end
endmodule

// File: rtl/tmr_buf16_regs.sv
module tmr_buf16_regs
  import tmr_buf16_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CW    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wrap,
  output ctrl_t             ctrl,
  output logic [CW-1:0]     cmp,
  output logic              ovf
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      cmp  <= '0;
    end else if (wr) begin
      case (addr)
        A_CMP_LO: cmp[BYTE_W-1:0]  <= wdata;
        A_CMP_HI: cmp[CW-1:BYTE_W] <= wdata;
        A_CTRL:   ctrl             <= ctrl_t'(wdata[CTRL_W-1:0]);
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                                   ovf <= 1'b0;
    else if (wrap)                                ovf <= 1'b1;
    else if (wr && addr == A_STAT && !wdata[0])   ovf <= 1'b0;
  end
endmodule

// File: rtl/tmr_buf16.sv
module tmr_buf16
  import tmr_buf16_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int SEL_W  = 2,
  localparam int CW    = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              count_en,
  input  logic              conv_en,
  output logic              soc_pulse,
  output logic              irq
);
  ctrl_t             ctrl;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     cmp;
  logic [BYTE_W-1:0] hbuf;
  logic              ovf, tick, match, wrap, cnt_load;
  logic              wr_lo, wr_hi, rd_lo, adv;

  assign wr_lo = bus_wr && (bus_addr == A_CNT_LO);
  assign wr_hi = bus_wr && (bus_addr == A_CNT_HI);
  assign rd_lo = bus_rd && (bus_addr == A_CNT_LO);
  assign adv   = ctrl.run && count_en;

  tmr_buf16_prescale #(.SEL_W(SEL_W)) u_pre (
    .clk(clk), .rst_n(rst_n), .adv(adv), .clr(wr_lo),
    .sel(SEL_W'(ctrl.psel)), .tick(tick)
  );

  tmr_buf16_count #(.BYTE_W(BYTE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .match(match),
    .wr_lo(wr_lo), .wr_hi(wr_hi), .rd_lo(rd_lo), .wide(ctrl.wide),
    .wdata(bus_wdata), .cnt(cnt), .hbuf(hbuf), .cnt_load(cnt_load), .wrap(wrap)
  );

  tmr_buf16_cmp #(.CW(CW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp(cmp), .mode(ctrl.cmp_mode),
    .tick(tick), .conv_en(conv_en), .match(match), .soc_pulse(soc_pulse)
  );

  tmr_buf16_regs #(.BYTE_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
    .wdata(bus_wdata), .wrap(wrap), .ctrl(ctrl), .cmp(cmp), .ovf(ovf)
  );

  assign irq = ovf && ctrl.irq_en;

  always_comb begin
    case (bus_addr)
      A_CNT_LO: bus_rdata = cnt[BYTE_W-1:0];
      A_CNT_HI: bus_rdata = ctrl.wide ? hbuf : cnt[CW-1:BYTE_W];
      A_CMP_LO: bus_rdata = cmp[BYTE_W-1:0];
      A_CMP_HI: bus_rdata = cmp[CW-1:BYTE_W];
      A_CTRL:   bus_rdata = BYTE_W'(ctrl);
      A_STAT:   bus_rdata = BYTE_W'(ovf);
      default:  bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tmr_buf16_chk.sv
module tmr_buf16_chk
  import tmr_buf16_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int CW    = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BYTE_W-1:0] bus_wdata,
  input logic              count_en,
  input logic              irq,
  input ctrl_t             ctrl,
  input logic [CW-1:0]     cnt,
  input logic              match,
  input logic              cnt_load,
  input logic              ovf
);
  AST_CMP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    match && !cnt_load |=> cnt == '0); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    match && bus_wr && bus_addr == A_CNT_LO |=> cnt[BYTE_W-1:0] == $past(bus_wdata)); // R9
  AST_NO_CMP_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(cnt) == {CW{1'b1}} && !$past(match)); // R10
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctrl.run && count_en) && !cnt_load |=> $stable(cnt)); // R11
  AST_OVF_CLEAR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf) |-> $past(bus_wr) && $past(bus_addr) == A_STAT && !$past(bus_wdata[0])); // R3
  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ovf); // R3
endmodule

bind tmr_buf16 tmr_buf16_chk #(.BYTE_W(BYTE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .count_en(count_en), .irq(irq), .ctrl(ctrl),
  .cnt(cnt), .match(match), .cnt_load(cnt_load), .ovf(ovf)
);

// File: tb/tmr_buf16_tb_top.sv
`timescale 1ns/1ps
module tmr_buf16_tb_top;
  localparam time TCLK = 20ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       count_en = 1'b0, conv_en = 1'b0;
  logic       soc_pulse, irq;

  int n_chk = 0, n_fail = 0, soc_seen = 0;
  bit done = 1'b0;

  always #(TCLK/2) clk = ~clk;

  tmr_buf16 dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .count_en(count_en), .conv_en(conv_en), .soc_pulse(soc_pulse), .irq(irq)
  );

  // behavioural reference state
  int m_cnt, m_buf, m_phase, m_ctrl, m_cmp, m_ovf, m_soc;

  function automatic int m_read(int a);
    case (a)
      0: return m_cnt % 256;
      1: return ((m_ctrl / 2) % 2 == 1) ? m_buf : m_cnt / 256;
      2: return m_cmp % 256;
      3: return m_cmp / 256;
      4: return m_ctrl;
      5: return m_ovf;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_buf = 0; m_phase = 0; m_ctrl = 0; m_cmp = 0; m_ovf = 0; m_soc = 0;
    end else begin
      int div, n_cnt, n_buf, n_phase, n_ctrl, n_cmp, n_ovf;
      bit running, wide, stepped, fired, wrapped, lo_w, hi_w;
      div     = 1 << ((m_ctrl / 4) % 4);
      wide    = (m_ctrl / 2) % 2 == 1;
      running = (m_ctrl % 2 == 1) && count_en;
      stepped = running && (m_phase == div - 1);
      fired   = stepped && ((m_ctrl / 16) % 2 == 1) && (m_cnt == m_cmp);
      lo_w    = bus_wr && bus_addr == 0;
      hi_w    = bus_wr && bus_addr == 1;
      n_phase = lo_w ? 0 : (running ? (stepped ? 0 : m_phase + 1) : m_phase);
      n_cnt = m_cnt; n_buf = m_buf; n_ctrl = m_ctrl; n_cmp = m_cmp; n_ovf = m_ovf;
      wrapped = 1'b0;
      if (lo_w)               n_cnt = (wide ? m_buf : m_cnt / 256) * 256 + bus_wdata;
      else if (hi_w && !wide) n_cnt = bus_wdata * 256 + m_cnt % 256;
      else if (fired)         n_cnt = 0;
      else if (stepped) begin
        if (m_cnt == 65535) begin n_cnt = 0; wrapped = 1'b1; end
        else n_cnt = m_cnt + 1;
      end
      if (hi_w && wide) n_buf = bus_wdata;
      else if (bus_rd && bus_addr == 0 && wide) n_buf = m_cnt / 256;
      if (bus_wr && bus_addr == 2) n_cmp = (m_cmp / 256) * 256 + bus_wdata;
      if (bus_wr && bus_addr == 3) n_cmp = bus_wdata * 256 + m_cmp % 256;
      if (bus_wr && bus_addr == 4) n_ctrl = bus_wdata % 64;
      if (wrapped) n_ovf = 1;
      else if (bus_wr && bus_addr == 5 && bus_wdata[0] == 1'b0) n_ovf = 0;
      m_soc = (fired && conv_en) ? 1 : 0;
      m_cnt = n_cnt; m_buf = n_buf; m_phase = n_phase; m_ctrl = n_ctrl;
      m_cmp = n_cmp; m_ovf = n_ovf;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock comparison with the model, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R3 irq", int'(irq), (m_ovf == 1 && (m_ctrl / 32) % 2 == 1) ? 1 : 0);
      check("R8 soc_pulse", int'(soc_pulse), m_soc);
      check("R4 read data", int'(bus_rdata), m_read(int'(bus_addr)));
      if (soc_pulse) soc_seen++;
    end
  end

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [2:0] a, output int d);
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    d = int'(bus_rdata);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic run_edges(input int n);
    @(posedge clk); #1;
    count_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 count_en = 1'b0;
  endtask

  task automatic set_cnt_narrow(input int v);
    wr_reg(3'd0, 8'(v % 256));
    wr_reg(3'd1, 8'(v / 256));
  endtask

  task automatic read_cnt_narrow(output int v);
    int lo, hi;
    rd_reg(3'd0, lo);
    rd_reg(3'd1, hi);
    v = hi * 256 + lo;
  endtask

  initial begin
    #(TCLK * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int v, lo, hi;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 6; a++) begin
      rd_reg(3'(a), v);
      check("R1 reset register", v, 0);
    end
    check("R1 irq after reset", int'(irq), 0);
    check("R1 soc after reset", int'(soc_pulse), 0);

    // R6: narrow direct access
    set_cnt_narrow(16'h1234);
    read_cnt_narrow(v);
    check("R6 narrow bytes", v, 16'h1234);

    // R5: wide high write only touches the holding register
    wr_reg(3'd4, 8'h02);
    wr_reg(3'd1, 8'hAB);
    rd_reg(3'd1, v);
    check("R5 holding reg after high write", v, 8'hAB);
    rd_reg(3'd0, lo);
    rd_reg(3'd1, hi);
    check("R5 live high untouched", hi, 8'h12);
    wr_reg(3'd1, 8'hAB);
    wr_reg(3'd0, 8'hCD);
    rd_reg(3'd0, lo);
    rd_reg(3'd1, hi);
    check("R5 committed value", hi * 256 + lo, 16'hABCD);

    // R4: snapshot while running across a high-byte carry
    wr_reg(3'd4, 8'h03);
    wr_reg(3'd1, 8'h12);
    wr_reg(3'd0, 8'hF0);
    @(posedge clk); #1 count_en = 1'b1;
    rd_reg(3'd0, lo);
    repeat (40) @(posedge clk);
    rd_reg(3'd1, hi);
    #1 count_en = 1'b0;
    check("R4 snapshot low", lo, 8'hF1);
    check("R4 snapshot high from holding reg", hi, 8'h12);

    // R2 / R11: prescaler ratios
    wr_reg(3'd4, 8'h0D);            // run, div 8
    set_cnt_narrow(0);
    run_edges(80);
    read_cnt_narrow(v);
    check("R2 div8 count", v, 10);
    repeat (20) @(posedge clk);
    read_cnt_narrow(v);
    check("R11 held with count_en low", v, 10);
    wr_reg(3'd4, 8'h05);            // run, div 2
    set_cnt_narrow(0);
    run_edges(10);
    read_cnt_narrow(v);
    check("R2 div2 count", v, 5);
    wr_reg(3'd4, 8'h0C);            // div 8, run clear
    set_cnt_narrow(0);
    run_edges(16);
    read_cnt_narrow(v);
    check("R11 held with run clear", v, 0);

    // R7: low write restarts phase, high write keeps it
    wr_reg(3'd4, 8'h0D);
    set_cnt_narrow(0);
    run_edges(5);
    wr_reg(3'd0, 8'h00);
    run_edges(3);
    read_cnt_narrow(v);
    check("R7 phase restarted by low write", v, 0);
    run_edges(5);
    read_cnt_narrow(v);
    check("R7 step after full period", v, 1);
    wr_reg(3'd0, 8'h00);
    run_edges(5);
    wr_reg(3'd1, 8'h00);
    run_edges(3);
    read_cnt_narrow(v);
    check("R7 phase kept by high write", v, 1);

    // R8: compare period of 5 with pulses
    wr_reg(3'd5, 8'h00);
    wr_reg(3'd2, 8'h04);
    wr_reg(3'd3, 8'h00);
    wr_reg(3'd4, 8'h11);
    set_cnt_narrow(0);
    conv_en = 1'b1;
    soc_seen = 0;
    run_edges(20);
    read_cnt_narrow(v);
    check("R8 count after 4 periods", v, 0);
    check("R8 pulse count", soc_seen, 4);
    conv_en = 1'b0;
    soc_seen = 0;
    run_edges(5);
    check("R8 pulse gated by conv_en", soc_seen, 0);

    // R9: write on the match cycle wins
    wr_reg(3'd2, 8'h03);
    set_cnt_narrow(3);
    @(posedge clk); #1;
    count_en = 1'b1; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 8'h80;
    @(posedge clk); #1;
    count_en = 1'b0; bus_wr = 1'b0;
    read_cnt_narrow(v);
    check("R9 write beats compare reset", v, 16'h0080);

    // R10: compare at all-ones does not flag overflow
    wr_reg(3'd2, 8'hFF);
    wr_reg(3'd3, 8'hFF);
    wr_reg(3'd5, 8'h00);
    set_cnt_narrow(16'hFFFE);
    conv_en = 1'b1; soc_seen = 0;
    run_edges(2);
    read_cnt_narrow(v);
    check("R10 count reset", v, 0);
    rd_reg(3'd5, v);
    check("R10 no overflow flag", v, 0);
    check("R10 pulse seen", soc_seen, 1);
    conv_en = 1'b0;

    // R3 / R2: wrap, flag, interrupt enable, clear semantics
    wr_reg(3'd4, 8'h01);
    set_cnt_narrow(16'hFFFE);
    run_edges(2);
    read_cnt_narrow(v);
    check("R2 wrap to zero", v, 0);
    rd_reg(3'd5, v);
    check("R3 flag set on wrap", v, 1);
    check("R3 irq masked", int'(irq), 0);
    wr_reg(3'd4, 8'h21);
    check("R3 irq enabled", int'(irq), 1);
    wr_reg(3'd5, 8'h01);
    rd_reg(3'd5, v);
    check("R3 write one ignored", v, 1);
    wr_reg(3'd5, 8'h00);
    rd_reg(3'd5, v);
    check("R3 write zero clears", v, 0);
    check("R3 irq drops", int'(irq), 0);

    repeat (4) @(posedge clk);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule